// File: doc/BRIEF.md
# ADC Power and Conversion Sequencer

This block is the digital controller of a low-power sampling converter. A single conversion-start line drives everything: its rising edge wakes the converter from the low-current state, and its falling edge stops tracking, captures the input into hold and starts a conversion. The analog conversion is modelled by a parallel data input that is captured at hold time. When a conversion finishes, the block looks at the start line. If it is high, the converter stays powered for the next sample (fast mode). If it is low, the converter drops back to the low-current state (power-saving mode).

Results leave through a serial read port. The port is opened by a rising edge on the start line and closed when the block powers down. A read frame is marked by a read-enable level. Each rising serial-clock edge inside the frame shifts out one bit, MSB first. A read that begins before a conversion ends returns the previous result. If a read is still open when a conversion finishes, the new result is held back until that read closes.

The states are OFF (low current), WAKE (power-up count), TRACK (input followed) and CONV (conversion count). The transitions are: OFF→WAKE on a start rise; WAKE→TRACK when the power-up count expires; TRACK→CONV on a start fall; CONV→TRACK at the end of a conversion with the start line high; CONV→OFF at the end of a conversion with the start line low.

Top module: `adcs_seq`

## Requirements
- R1: During and just after reset the block is in OFF, and powered, busy, ready, err and dout are all 0.
- R2: A rising edge of convst in OFF enters WAKE. powered (1 in TRACK or CONV only) goes to 1 exactly PWRUP_CYC clock cycles after the clock edge that saw the rise.
- R3: A falling edge of convst in TRACK captures sample_in into hold and enters CONV. busy is 1 for exactly CONV_CYC cycles, and later changes of sample_in do not affect the result.
- R4: If convst is high at the clock edge that ends a conversion, the block returns to TRACK and powered stays 1.
- R5: If convst is low at the clock edge that ends a conversion, the block enters OFF with powered 0 and the serial port closes. A read attempted while the port is closed shifts out all zeros.
- R6: When no read is open at the end of a conversion, the held sample becomes the current result and ready is 1 from the next cycle.
- R7: A rise of rd_en while the port is open loads the current result and clears ready. dout then shows bit 7 first and moves one bit lower on each rising edge of sclk.
- R8: A read that starts while a conversion is running returns the result of the previous conversion.
- R9: If rd_en is still high when a conversion ends, ready stays 0 and the new result is latched only on the cycle rd_en falls. ready then rises.
- R10: A falling edge of convst in OFF or WAKE starts no conversion, does not change the power-up progress, and raises err for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| convst | input | 1 | Conversion start / power control line |
| sclk | input | 1 | Serial read clock, sampled by clk |
| rd_en | input | 1 | Read frame active |
| sample_in | input | DATA_W | Data standing in for the analog result |
| dout | output | 1 | Serial result bit, MSB first |
| powered | output | 1 | Converter awake (TRACK or CONV) |
| busy | output | 1 | Conversion in progress |
| ready | output | 1 | Unread result latched |
| err | output | 1 | One-cycle pulse on an ignored start fall |

## Verification
The bound checker watches the power decision on every cycle. A conversion may only begin from a powered state. The end of a conversion must leave the block powered exactly when the start line was high at that edge. err may only pulse while the block was unpowered. The scenarios are needed to show the cycle-exact power-up and conversion lengths, the sample being frozen at hold, and which result a read returns in each case: early, late, overlapping the end, or after power-down. They also show that latching is deferred when a read overlaps the end of a conversion.

// File: rtl/adcs_pkg.sv
package adcs_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WAKE  = 2'd1,
        ST_TRACK = 2'd2,
        ST_CONV  = 2'd3
    } adcs_state_e;
endpackage

// File: rtl/adcs_edge.sv
module adcs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic din_q;

    always_ff @(posedge clk) begin
        if (!rst_n) din_q <= 1'b0;
        else        din_q <= din;
    end

    assign rise = din & ~din_q;
    assign fall = ~din & din_q;
endmodule

// File: rtl/adcs_fsm.sv
module adcs_fsm
    import adcs_pkg::*;
#(
    parameter int PWRUP_CYC = 375,
    parameter int CONV_CYC  = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cv_lvl,
    input  logic        cv_rise,
    input  logic        cv_fall,
    output adcs_state_e state,
    output logic        hold_stb,
    output logic        done_stb,
    output logic        pdn_stb,
    output logic        err
);
    localparam int MAXC = (PWRUP_CYC > CONV_CYC) ? PWRUP_CYC : CONV_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] PW_LD = CW'(PWRUP_CYC - 1);
    localparam logic [CW-1:0] CV_LD = CW'(CONV_CYC - 1);

    adcs_state_e   nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          err_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
            cnt   <= '0;
            err   <= 1'b0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
            err   <= err_nxt;
        end
    end

    // next state and strobes
    always_comb begin
        nxt      = state;
        cnt_nxt  = cnt;
        hold_stb = 1'b0;
        done_stb = 1'b0;
        pdn_stb  = 1'b0;
        err_nxt  = 1'b0;
        unique case (state)
            ST_OFF: begin
                if (cv_fall) err_nxt = 1'b1;
                if (cv_rise) begin
                    nxt     = ST_WAKE;
                    cnt_nxt = PW_LD;
                end
            end
            ST_WAKE: begin
                if (cv_fall) err_nxt = 1'b1;
                if (cnt == '0) nxt = ST_TRACK;
                else           cnt_nxt = cnt - 1'b1;
            end
            ST_TRACK: begin
                if (cv_fall) begin
                    nxt      = ST_CONV;
                    cnt_nxt  = CV_LD;
                    hold_stb = 1'b1;
                end
            end
            ST_CONV: begin
                if (cnt == '0) begin
                    done_stb = 1'b1;
                    if (cv_lvl) nxt = ST_TRACK;
                    else begin
                        nxt     = ST_OFF;
                        pdn_stb = 1'b1;
                    end
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/adcs_shift.sv
module adcs_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample_in,
    input  logic              sclk,
    input  logic              hold_stb,
    input  logic              done_stb,
    input  logic              pdn_stb,
    input  logic              cv_rise,
    input  logic              rd_rise,
    input  logic              rd_fall,
    output logic              dout,
    output logic              ready
);
    logic [DATA_W-1:0] hold_q, res_q, shreg;
    logic port_en, rd_act, pend, sclk_q;
    logic rd_start, rd_end, sclk_rise, latch_now;

    assign rd_start  = rd_rise & port_en;
    assign rd_end    = rd_fall & rd_act;
    assign sclk_rise = sclk & ~sclk_q;
    assign latch_now = (done_stb & (~rd_act | rd_end)) | (rd_end & pend);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            res_q   <= '0;
            shreg   <= '0;
            port_en <= 1'b0;
            rd_act  <= 1'b0;
            pend    <= 1'b0;
            ready   <= 1'b0;
            sclk_q  <= 1'b0;
        end else begin
            sclk_q <= sclk;
            if (hold_stb) hold_q <= sample_in;

            if (pdn_stb)      port_en <= 1'b0;
            else if (cv_rise) port_en <= 1'b1;

            if (rd_start)    rd_act <= 1'b1;
            else if (rd_end) rd_act <= 1'b0;

            if (latch_now) begin
                res_q <= hold_q;
                pend  <= 1'b0;
            end else if (done_stb) begin
                pend  <= 1'b1;
            end

            if (latch_now)     ready <= 1'b1;
            else if (rd_start) ready <= 1'b0;

            if (rd_start)
                shreg <= res_q;
            else if (rd_act && sclk_rise)
                shreg <= {shreg[DATA_W-2:0], 1'b0};
        end
    end

    assign dout = rd_act & shreg[DATA_W-1];
endmodule

// File: rtl/adcs_seq.sv
module adcs_seq
    import adcs_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int PWRUP_CYC = 375,
    parameter int CONV_CYC  = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              convst,
    input  logic              sclk,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] sample_in,
    output logic              dout,
    output logic              powered,
    output logic              busy,
    output logic              ready,
    output logic              err
);
    adcs_state_e state;
    logic cv_rise, cv_fall, rd_rise, rd_fall;
    logic hold_stb, done_stb, pdn_stb;

    adcs_edge i_cv_edge (
        .clk(clk), .rst_n(rst_n), .din(convst), .rise(cv_rise), .fall(cv_fall)
    );

    adcs_edge i_rd_edge (
        .clk(clk), .rst_n(rst_n), .din(rd_en), .rise(rd_rise), .fall(rd_fall)
    );

    adcs_fsm #(.PWRUP_CYC(PWRUP_CYC), .CONV_CYC(CONV_CYC)) i_fsm (
        .clk(clk), .rst_n(rst_n), .cv_lvl(convst), .cv_rise(cv_rise),
        .cv_fall(cv_fall), .state(state), .hold_stb(hold_stb),
        .done_stb(done_stb), .pdn_stb(pdn_stb), .err(err)
    );

    adcs_shift #(.DATA_W(DATA_W)) i_shift (
        .clk(clk), .rst_n(rst_n), .sample_in(sample_in), .sclk(sclk),
        .hold_stb(hold_stb), .done_stb(done_stb), .pdn_stb(pdn_stb),
        .cv_rise(cv_rise), .rd_rise(rd_rise), .rd_fall(rd_fall),
        .dout(dout), .ready(ready)
    );

    // status outputs
    always_comb begin
        powered = 1'b0;
        busy    = 1'b0;
        unique case (state)
            ST_OFF, ST_WAKE: powered = 1'b0;
            ST_TRACK:        powered = 1'b1;
            ST_CONV: begin
                powered = 1'b1;
                busy    = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/adcs_seq_chk.sv
module adcs_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic convst,
    input logic powered,
    input logic busy,
    input logic err
);
    // R3
    conv_from_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(powered));

    // R4
    stay_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(convst)) |-> powered);

    // R5
    power_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(convst)) |-> !powered);

    // R10
    err_when_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!$past(powered) && !busy));

    // R10
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);
endmodule

bind adcs_seq adcs_seq_chk i_chk (
    .clk(clk), .rst_n(rst_n), .convst(convst),
    .powered(powered), .busy(busy), .err(err)
);

// File: tb/test_adcs_seq.sv
module test_adcs_seq;
    localparam int DW = 8;
    localparam int PW = 4;
    localparam int CV = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic convst = 1'b0, sclk = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] sample_in = '0;
    logic dout, powered, busy, ready, err;

    int n_chk = 0, n_bad = 0;
    logic [DW-1:0] exp_q[$];

    always #2 clk = ~clk;

    adcs_seq #(.DATA_W(DW), .PWRUP_CYC(PW), .CONV_CYC(CV)) i_adcs_seq (
        .clk(clk), .rst_n(rst_n), .convst(convst), .sclk(sclk), .rd_en(rd_en),
        .sample_in(sample_in), .dout(dout), .powered(powered), .busy(busy),
        .ready(ready), .err(err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_byte(input logic [DW-1:0] v);
        exp_q.push_back(v);
    endtask

    // monitor: shifts out one byte and compares it with the scoreboard
    task automatic read_byte(input string req, input bit open_already);
        logic [DW-1:0] got;
        logic [DW-1:0] want;
        if (!open_already) begin
            rd_en = 1'b1;
            @(negedge clk);
        end
        for (int i = DW - 1; i >= 0; i--) begin
            got[i] = dout;
            sclk = 1'b1;
            @(negedge clk);
            sclk = 1'b0;
            @(negedge clk);
        end
        rd_en = 1'b0;
        @(negedge clk);
        want = exp_q.pop_front();
        chk(req, int'(got), int'(want));
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4 * CV && busy; i++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 powered", int'(powered), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 ready", int'(ready), 0);
        chk("R1 err/dout", int'({err, dout}), 0);

        // R2 wake-up, with a fall during WAKE (R10)
        convst = 1'b1;
        @(negedge clk);
        chk("R2 not yet powered", int'(powered), 0);
        convst = 1'b0;
        @(negedge clk);
        chk("R10 err pulse", int'(err), 1);
        chk("R10 no conversion", int'(busy), 0);
        @(negedge clk);
        chk("R10 err one cycle", int'(err), 0);
        @(negedge clk);
        chk("R2 still waking", int'(powered), 0);
        @(negedge clk);
        chk("R2 powered after PWRUP_CYC", int'(powered), 1);

        // R3/R5/R6 conversion that ends with convst low
        convst = 1'b1;
        @(negedge clk);
        sample_in = 8'hA5;
        convst = 1'b0;
        @(negedge clk);
        sample_in = 8'h00;
        chk("R3 busy start", int'(busy), 1);
        repeat (CV - 1) @(negedge clk);
        chk("R3 busy last cycle", int'(busy), 1);
        @(negedge clk);
        chk("R3 busy length", int'(busy), 0);
        chk("R6 ready", int'(ready), 1);
        chk("R5 powered down", int'(powered), 0);
        expect_byte(8'h00);
        read_byte("R5 port closed", 1'b0);

        // R4/R7 fast mode: convst raised during conversion
        convst = 1'b1;
        repeat (PW + 1) @(negedge clk);
        chk("R2 powered again", int'(powered), 1);
        sample_in = 8'h3C;
        convst = 1'b0;
        @(negedge clk);
        convst = 1'b1;
        sample_in = 8'hFF;
        wait_idle();
        chk("R4 stays powered", int'(powered), 1);
        expect_byte(8'h3C);
        read_byte("R7 current result", 1'b0);
        chk("R7 ready cleared", int'(ready), 0);

        // R8 read fully inside a conversion
        sample_in = 8'h96;
        convst = 1'b0;
        @(negedge clk);
        convst = 1'b1;
        expect_byte(8'h3C);
        read_byte("R8 previous result", 1'b0);
        chk("R8 still converting", int'(busy), 1);
        wait_idle();
        chk("R6 ready after end", int'(ready), 1);
        expect_byte(8'h96);
        read_byte("R7 new result", 1'b0);

        // R9 read overlapping the end of a conversion
        sample_in = 8'h5A;
        convst = 1'b0;
        @(negedge clk);
        convst = 1'b1;
        repeat (CV - 6) @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        wait_idle();
        chk("R9 powered after end", int'(powered), 1);
        chk("R9 ready deferred", int'(ready), 0);
        expect_byte(8'h96);
        read_byte("R9 old data during overlap", 1'b1);
        chk("R9 ready after read", int'(ready), 1);
        expect_byte(8'h5A);
        read_byte("R9 deferred result", 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule